// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sender

This block holds the command that software builds to interrupt another processor, and turns it into one outbound message. The command has a low word and a high word. The low word carries the vector, the delivery mode, the level, the trigger mode and a destination shorthand. The high word carries the destination. Software writes these registers through a simple write port. The block presents the message on a valid/ready interface, and a read port returns the whole 64-bit command at any time.

Software picks one of two access styles with a mode input. In the legacy style the two 32-bit words are written one at a time. The destination is the top byte of the high word. A write to the high word only stages it, and a write to the low word launches the send. Software polls a busy bit in the low word until the message has been taken. In the extended style a single 64-bit write carries the full 32-bit destination in its upper half and the command in its lower half, and that write launches the send. The busy bit always reads zero in this style.

The outbound interface follows these back-pressure rules. `msg_valid_o` rises one cycle after a launching write. While `msg_ready_i` is low, the valid signal and every message field hold still. The message is consumed on the first clock edge where valid and ready are both high. Only one message is ever outstanding. A launching write that arrives while a message is outstanding is dropped, and the block flags it with a one-cycle error pulse.

Top module: `icr_sender`

## Requirements
- R1: After reset, `rd_data_o` is 0, `msg_valid_o` is 0, `send_err_o` is 0, and the unit is in legacy mode.
- R2: In legacy mode, a write with `wr_sel_i`=1 stores `wr_data_i[31:0]` as the high word (read back in `rd_data_o[63:32]`). It never launches a message, and it never changes a message already outstanding.
- R3: In legacy mode, a write with `wr_sel_i`=0 while idle stores `wr_data_i[31:0]` as the low word (bit 12 stored as 0) and raises `msg_valid_o` on the next cycle. The message fields are: vector = bits 7:0, delivery mode = bits 10:8, level = bit 14, trigger = bit 15, shorthand = bits 19:18, and destination = high word bits 31:24 zero-extended to 32 bits.
- R4: In legacy mode, `rd_data_o[12]` reads 1 from the cycle after a launch up to and including the cycle of the accepting handshake, and reads 0 after it.
- R5: While `msg_valid_o` is 1 and `msg_ready_i` is 0, valid and all message fields stay unchanged. A cycle with valid and ready both high consumes the message, and valid is 0 on the next cycle unless a new launch occurs.
- R6: A launching write (legacy `wr_sel_i`=0 or extended `wr_sel_i`=2) made while a message is outstanding changes no register and no message field. It produces `send_err_o`=1 for exactly the next cycle.
- R7: In extended mode, a write with `wr_sel_i`=2 while idle stores `wr_data_i[63:32]` as the high word and `wr_data_i[31:0]` as the low word (bit 12 stored as 0). It launches a message whose destination is the full `wr_data_i[63:32]`, with the other fields decoded as in R3.
- R8: In extended mode, `rd_data_o[12]` reads 0 even while a message is outstanding.
- R9: A write whose `wr_sel_i` does not belong to the active mode is ignored. In legacy mode that is `wr_sel_i`=2 or 3; in extended mode it is `wr_sel_i`=0, 1 or 3. An ignored write changes no register, launches nothing, and raises no error.
- R10: `ext_mode_i` (0 = legacy, 1 = extended) is captured on every clock edge where no message is outstanding, and it governs decode from the next cycle. Changes made while a message is outstanding take effect only after it is accepted.
- R11: `rd_data_o` returns the high word in bits 63:32 and the low word in bits 31:0, with bit 12 replaced by the busy status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | Access style request: 0 legacy, 1 extended |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 low word, 1 high word, 2 full 64-bit command |
| wr_data_i | input | 64 | Write data (32-bit writes use bits 31:0) |
| rd_data_o | output | 64 | Current command with busy status in bit 12 |
| msg_valid_o | output | 1 | Outbound message valid |
| msg_ready_i | input | 1 | Outbound message accepted by the receiver |
| msg_dest_o | output | 32 | Message destination |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_level_o | output | 1 | Message level |
| msg_trig_o | output | 1 | Message trigger mode |
| msg_short_o | output | 2 | Message destination shorthand |
| send_err_o | output | 1 | One-cycle pulse for a launching write that was dropped because the unit was busy |

## Verification
The bench targets writes that land exactly on the accepting cycle. A design that frees the busy state before checking the write would send twice instead of dropping the write and pulsing the error. It re-stages the high word while a message is held back by the receiver. A design that drives the outbound destination straight from the register would then show the destination changing mid-handshake. It flips the mode input while a message is outstanding and checks that the busy bit and the decode keep the old style until the handshake completes. It also checks that the legacy destination uses only the top byte of the high word, while the extended destination carries all 32 bits.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int ICR_WORD_W = 32;
  localparam int ICR_VEC_W  = 8;
  localparam int ICR_DM_W   = 3;
  localparam int ICR_SH_W   = 2;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_WIDE = 2'd2,
    SEL_NONE = 2'd3
  } icr_sel_e;

  typedef struct packed {
    logic [ICR_WORD_W-1:0] dest;
    logic [ICR_VEC_W-1:0]  vector;
    logic [ICR_DM_W-1:0]   dmode;
    logic                  level;
    logic                  trig;
    logic [ICR_SH_W-1:0]   short_hand;
  } icr_msg_t;
endpackage

// File: rtl/icr_regs.sv
module icr_regs
  import icr_pkg::*;
#(
  parameter int LEG_DEST_W = 8,
  parameter int BUSY_POS   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ext_mode_i,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [2*ICR_WORD_W-1:0] wr_data_i,
  input  logic                    pending_i,
  output logic                    mode_o,
  output logic                    launch_o,
  output icr_msg_t                msg_o,
  output logic                    send_err_o,
  output logic [2*ICR_WORD_W-1:0] rd_data_o
);
  localparam int WW      = ICR_WORD_W;
  localparam int LEG_LSB = WW - LEG_DEST_W;

  logic          mode_q;
  logic [WW-1:0] lo_q, hi_q;
  logic          err_q;
  logic          wr_lo, wr_hi, wr_wide, req;
  logic [WW-1:0] lo_new, dest_new, busy_mask;

  always_comb begin
    wr_lo   = wr_en_i && (wr_sel_i == SEL_LO)   && !mode_q;
    wr_hi   = wr_en_i && (wr_sel_i == SEL_HI)   && !mode_q;
    wr_wide = wr_en_i && (wr_sel_i == SEL_WIDE) &&  mode_q;
    req     = wr_lo || wr_wide;
    launch_o = req && !pending_i;
    busy_mask = WW'(1) << BUSY_POS;
    lo_new  = wr_data_i[WW-1:0] & ~busy_mask;
    if (mode_q) dest_new = wr_data_i[2*WW-1:WW];
    else        dest_new = WW'(hi_q[WW-1:LEG_LSB]);
  end

  always_comb begin
    msg_o.dest       = dest_new;
    msg_o.vector     = lo_new[7:0];
    msg_o.dmode      = lo_new[10:8];
    msg_o.level      = lo_new[14];
    msg_o.trig       = lo_new[15];
    msg_o.short_hand = lo_new[19:18];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (!pending_i) mode_q <= ext_mode_i;
      err_q <= req && pending_i;
      if (wr_hi) hi_q <= wr_data_i[WW-1:0];
      if (launch_o) begin
        lo_q <= lo_new;
        if (wr_wide) hi_q <= wr_data_i[2*WW-1:WW];
      end
    end
  end

  assign mode_o     = mode_q;
  assign send_err_o = err_q;
  assign rd_data_o  = {hi_q, lo_q | ((pending_i && !mode_q) ? busy_mask : '0)};
endmodule

// File: rtl/icr_launch.sv
module icr_launch
  import icr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch_i,
  input  icr_msg_t msg_i,
  input  logic     ready_i,
  output logic     valid_o,
  output icr_msg_t msg_o
);
  logic     valid_q;
  icr_msg_t msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (launch_i) begin
      valid_q <= 1'b1;
      msg_q   <= msg_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
endmodule

// File: rtl/icr_sender.sv
module icr_sender
  import icr_pkg::*;
#(
  parameter int LEG_DEST_W = 8,
  parameter int BUSY_POS   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [63:0] wr_data_i,
  output logic [63:0] rd_data_o,
  output logic        msg_valid_o,
  input  logic        msg_ready_i,
  output logic [31:0] msg_dest_o,
  output logic [7:0]  msg_vector_o,
  output logic [2:0]  msg_dmode_o,
  output logic        msg_level_o,
  output logic        msg_trig_o,
  output logic [1:0]  msg_short_o,
  output logic        send_err_o
);
  logic     mode_q;
  logic     launch;
  icr_msg_t staged_msg, held_msg;

  icr_regs #(.LEG_DEST_W(LEG_DEST_W), .BUSY_POS(BUSY_POS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode_i (ext_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .pending_i  (msg_valid_o),
    .mode_o     (mode_q),
    .launch_o   (launch),
    .msg_o      (staged_msg),
    .send_err_o (send_err_o),
    .rd_data_o  (rd_data_o)
  );

  icr_launch u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .msg_i    (staged_msg),
    .ready_i  (msg_ready_i),
    .valid_o  (msg_valid_o),
    .msg_o    (held_msg)
  );

  assign msg_dest_o   = held_msg.dest;
  assign msg_vector_o = held_msg.vector;
  assign msg_dmode_o  = held_msg.dmode;
  assign msg_level_o  = held_msg.level;
  assign msg_trig_o   = held_msg.trig;
  assign msg_short_o  = held_msg.short_hand;
endmodule

// File: rtl/icr_sender_chk.sv
module icr_sender_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_q,
  input logic        wr_en_i,
  input logic [63:0] rd_data_o,
  input logic        msg_valid_o,
  input logic        msg_ready_i,
  input logic [31:0] msg_dest_o,
  input logic [7:0]  msg_vector_o,
  input logic        send_err_o
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_dest_o) && $stable(msg_vector_o)); // R5

  AST_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    send_err_o |-> $past(msg_valid_o) && $past(wr_en_i)); // R6

  AST_LAUNCH_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid_o) |-> $past(wr_en_i)); // R3

  AST_LEGACY_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> rd_data_o[12] == msg_valid_o); // R4

  AST_EXT_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !rd_data_o[12]); // R8

  AST_LEGACY_DEST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !mode_q |-> msg_dest_o[31:8] == 24'd0); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_valid_o) |-> $stable(mode_q)); // R10
endmodule

bind icr_sender icr_sender_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .wr_en_i      (wr_en_i),
  .rd_data_o    (rd_data_o),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_dest_o   (msg_dest_o),
  .msg_vector_o (msg_vector_o),
  .send_err_o   (send_err_o)
);

// File: tb/tb_icr_sender.sv
module tb_icr_sender;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [63:0] wr_data_i = 64'd0;
  logic        msg_ready_i = 1'b0;
  logic [63:0] rd_data_o;
  logic        msg_valid_o;
  logic [31:0] msg_dest_o;
  logic [7:0]  msg_vector_o;
  logic [2:0]  msg_dmode_o;
  logic        msg_level_o, msg_trig_o, send_err_o;
  logic [1:0]  msg_short_o;

  icr_sender dut (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_dest_o(msg_dest_o),
    .msg_vector_o(msg_vector_o), .msg_dmode_o(msg_dmode_o), .msg_level_o(msg_level_o),
    .msg_trig_o(msg_trig_o), .msg_short_o(msg_short_o), .send_err_o(send_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [31:0] m_hi, m_lo, m_snap_lo, m_dest;
  bit          m_pend, m_mode, m_err;

  task automatic check(input string name, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hi = 0; m_lo = 0; m_snap_lo = 0; m_dest = 0;
    m_pend = 0; m_mode = 0; m_err = 0;
  endtask

  task automatic model_clock();
    bit old_pend;
    bit is_lo, is_hi, is_wide;
    old_pend = m_pend;
    is_lo   = wr_en_i && wr_sel_i == 2'd0 && !m_mode;
    is_hi   = wr_en_i && wr_sel_i == 2'd1 && !m_mode;
    is_wide = wr_en_i && wr_sel_i == 2'd2 &&  m_mode;
    m_err = 0;
    if (old_pend && msg_ready_i) m_pend = 0;
    if (is_hi) m_hi = wr_data_i[31:0];
    if (is_lo || is_wide) begin
      if (old_pend) m_err = 1;
      else begin
        m_lo = wr_data_i[31:0];
        m_lo[12] = 1'b0;
        m_snap_lo = m_lo;
        if (is_wide) begin
          m_hi = wr_data_i[63:32];
          m_dest = wr_data_i[63:32];
        end else begin
          m_dest = {24'd0, m_hi[31:24]};
        end
        m_pend = 1;
      end
    end
    if (!old_pend) m_mode = ext_mode_i;
  endtask

  task automatic compare();
    logic [31:0] lo_view;
    lo_view = m_lo;
    lo_view[12] = m_pend && !m_mode;
    check("rd_data", rd_data_o, {m_hi, lo_view});
    check("valid", 64'(msg_valid_o), 64'(m_pend));
    check("send_err", 64'(send_err_o), 64'(m_err));
    if (m_pend) begin
      check("dest", 64'(msg_dest_o), 64'(m_dest));
      check("vector", 64'(msg_vector_o), 64'(m_snap_lo[7:0]));
      check("dmode", 64'(msg_dmode_o), 64'(m_snap_lo[10:8]));
      check("level", 64'(msg_level_o), 64'(m_snap_lo[14]));
      check("trig", 64'(msg_trig_o), 64'(m_snap_lo[15]));
      check("short", 64'(msg_short_o), 64'(m_snap_lo[19:18]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_clock(); else model_reset();
    #1;
    compare();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    step();
    wr_en_i = 1'b0; wr_data_i = 64'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    tag = "R1";
    idle(2);
    rst_n = 1'b1;
    idle(1);

    tag = "R2";                        // stage destination only
    wr(2'd1, 64'h0000_0000_AB00_0000);
    idle(2);

    tag = "R3";                        // vector 0x31, dmode 5, level 1, shorthand 3
    wr(2'd0, 64'h0000_0000_000C_5531);
    tag = "R5";
    idle(3);
    tag = "R2";                        // re-stage while held: payload untouched
    wr(2'd1, 64'h0000_0000_1200_0000);
    tag = "R6";
    wr(2'd0, 64'h0000_0000_0000_00FF);
    idle(1);
    tag = "R4";
    msg_ready_i = 1'b1;
    idle(1);
    msg_ready_i = 1'b0;
    idle(1);

    tag = "R6";                        // write on the accepting cycle is dropped
    wr(2'd0, 64'h0000_0000_0000_9042);
    msg_ready_i = 1'b1;
    wr(2'd0, 64'h0000_0000_0000_0077);
    msg_ready_i = 1'b0;
    idle(1);

    tag = "R9";                        // wide write in legacy mode ignored
    wr(2'd2, 64'hDEAD_BEEF_0000_1234);
    wr(2'd3, 64'h0000_0000_FFFF_FFFF);
    idle(1);

    tag = "R10";                       // mode change deferred while pending
    wr(2'd0, 64'h0000_0000_0000_8A10);
    ext_mode_i = 1'b1;
    idle(3);
    msg_ready_i = 1'b1;
    idle(1);
    msg_ready_i = 1'b0;
    idle(2);

    tag = "R7";
    wr(2'd2, 64'h8765_4321_0004_1F7E);
    tag = "R8";
    idle(2);
    tag = "R9";
    wr(2'd0, 64'h0000_0000_0000_0001);
    wr(2'd1, 64'h0000_0000_5500_0000);
    tag = "R6";
    wr(2'd2, 64'h1111_1111_0000_1001);
    tag = "R5";
    msg_ready_i = 1'b1;
    idle(1);
    msg_ready_i = 1'b0;
    tag = "R11";
    wr(2'd2, 64'h0000_00FF_FFFF_FFFF);
    msg_ready_i = 1'b1;
    idle(2);
    msg_ready_i = 1'b0;

    tag = "R10";                       // back to legacy while idle
    ext_mode_i = 1'b0;
    idle(2);
    tag = "R3";
    wr(2'd1, 64'h0000_0000_C300_0000);
    wr(2'd0, 64'h0000_0000_0008_0620);
    msg_ready_i = 1'b1;
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule